// File: doc/BRIEF.md
# Converter Sample Packer with Tail Bits

This block takes 14-bit converter samples, one per handshake, and widens each one to a 16-bit word for a serial-link transport layer. The sample fills the upper fourteen bits. The two spare low bits are filled from one of four sources: a fixed tail pattern, pseudo-random tail bits, one control bit plus one tail bit, or two control bits. The finished word leaves the block as two octets, high octet first. Both sides use a valid/ready handshake.

The spare-bit source is chosen on every accepted sample by `mode_i`. A 3-bit `tail_cfg_i` setting does two jobs. It supplies the fixed tail value, and it seeds a 3-bit LFSR that produces the pseudo-random tail bits. A continuous input stream with an always-ready sink produces one octet per clock cycle. While the sink stalls, the pending octet is held unchanged.

Top module: `smp_pack_top`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `oct_valid_o` is 0 and `in_ready_o` is 1.
- R2: An accepted sample S is placed in word bits [15:2]. The first octet sent is S[13:6]. The second octet carries S[5:0] in its bits [7:2].
- R3: Each word is sent as exactly two octets in order: first word bits [15:8], then bits [7:0]. `oct_first_o` is 1 on the first octet and 0 on the second.
- R4: In mode 0 (fixed tail), word bits [1:0] equal `tail_cfg_i[1:0]`. A setting of 0 therefore gives tail bits 0b00.
- R5: In mode 1 (pseudo-random tail), word bits [1:0] equal the two low bits of a 3-bit LFSR state s.
  - The state advances to {s[1:0], s[2]^s[1]} on each sample accepted in mode 1.
  - On any cycle where `mode_i` is not 1, the state is loaded with `tail_cfg_i`, or with 3'b001 if that setting is zero.
  - After reset the state is 3'b001.
- R6: In mode 2 (one control bit), word bit 1 equals `ctrl_i[0]` and word bit 0 equals `tail_cfg_i[0]`.
- R7: In mode 3 (two control bits), word bits [1:0] equal `ctrl_i[1:0]`.
- R8: While `oct_valid_o` is 1 and `oct_ready_i` is 0, `oct_o` and `oct_first_o` hold their values and `oct_valid_o` stays 1 on the next cycle.
- R9: `in_ready_o` is 1 exactly when no octet is pending, or when the pending octet is a second octet and `oct_ready_i` is 1.
- R10: With `in_valid_i` and `oct_ready_i` held at 1, one octet is delivered on every cycle once the first word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| sample_i | input | 14 | Converter sample |
| ctrl_i | input | 2 | Per-sample control bits |
| mode_i | input | 2 | Spare-bit source: 0 fixed, 1 pseudo-random, 2 one control bit, 3 two control bits |
| tail_cfg_i | input | 3 | Fixed tail value and LFSR seed |
| oct_valid_o | output | 1 | Octet valid |
| oct_ready_i | input | 1 | Sink accepts the octet |
| oct_o | output | 8 | Output octet |
| oct_first_o | output | 1 | Octet is the high half of a word |

## Verification
The assertions check the handshake behaviour on every cycle:
- octets are held while the sink stalls;
- a loaded word always starts with its high octet and continues with its low octet;
- input acceptance follows the pending-octet state;
- the output stays idle during reset.

The spare-bit contents can only be shown by the bench's scenarios. These are the mode mux, the fixed-value path and the LFSR sequence with its reload and zero-seed substitution. The bench compares every delivered octet against a reference word built from the sample, the mode and a separately written LFSR model. It also measures full-rate streaming.

// File: rtl/smp_pack_pkg.sv
package smp_pack_pkg;
  typedef enum logic [1:0] {
    SPARE_FIX  = 2'd0,
    SPARE_PRN  = 2'd1,
    SPARE_CTL1 = 2'd2,
    SPARE_CTL2 = 2'd3
  } spare_mode_e;
endpackage

// File: rtl/smp_tail_lfsr.sv
module smp_tail_lfsr #(
  parameter int          LW   = 3,
  parameter logic [LW-1:0] TAPS = 3'b110
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] seed_i,
  input  logic          adv_i,
  output logic [LW-1:0] state_o
);
  logic [LW-1:0] st_q;
  logic [LW-1:0] seed_fix;

  // all-zero state would lock the register
  assign seed_fix = (seed_i == '0) ? LW'(1) : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= LW'(1);
    else if (load_i) st_q <= seed_fix;
    else if (adv_i)  st_q <= {st_q[LW-2:0], ^(st_q & TAPS)};
  end

  assign state_o = st_q;
endmodule

// File: rtl/smp_word_former.sv
module smp_word_former
  import smp_pack_pkg::*;
#(
  parameter int SMP_W  = 14,
  parameter int WORD_W = 16,
  parameter int CFG_W  = 3
) (
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [1:0]        ctrl_i,
  input  spare_mode_e       mode_i,
  input  logic [CFG_W-1:0]  tail_cfg_i,
  input  logic [CFG_W-1:0]  prn_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SPARE_W = WORD_W - SMP_W;

  logic [SPARE_W-1:0] spare;

  always_comb begin
    unique case (mode_i)
      SPARE_FIX:  spare = tail_cfg_i[SPARE_W-1:0];
      SPARE_PRN:  spare = prn_i[SPARE_W-1:0];
      SPARE_CTL1: spare = {ctrl_i[0], tail_cfg_i[0]};
      default:    spare = ctrl_i;
    endcase
  end

  assign word_o = {sample_i, spare};
endmodule

// File: rtl/smp_oct_serializer.sv
module smp_oct_serializer #(
  parameter int WORD_W = 16,
  parameter int OCT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] word_i,
  output logic              oct_valid_o,
  input  logic              oct_ready_i,
  output logic [OCT_W-1:0]  oct_o,
  output logic              oct_first_o
);
  localparam int NUM_OCT = WORD_W / OCT_W;
  localparam int CW      = (NUM_OCT > 1) ? $clog2(NUM_OCT) : 1;

  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     idx_q;
  logic              vld_q;
  logic              last;
  logic              in_fire;
  logic              out_fire;
  logic [WORD_W-1:0] shifted;

  assign last       = (idx_q == CW'(NUM_OCT - 1));
  assign in_ready_o = !vld_q || (last && oct_ready_i);
  assign in_fire    = in_valid_i && in_ready_o;
  assign out_fire   = vld_q && oct_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else if (in_fire) begin
      word_q <= word_i;
      idx_q  <= '0;
      vld_q  <= 1'b1;
    end else if (out_fire) begin
      if (last) vld_q <= 1'b0;
      else      idx_q <= idx_q + CW'(1);
    end
  end

  // most significant octet leaves first
  assign shifted     = word_q >> (OCT_W * (NUM_OCT - 1 - int'(idx_q)));
  assign oct_o       = shifted[OCT_W-1:0];
  assign oct_valid_o = vld_q;
  assign oct_first_o = vld_q && (idx_q == '0);
endmodule

// File: rtl/smp_pack_top.sv
module smp_pack_top
  import smp_pack_pkg::*;
#(
  parameter int SMP_W  = 14,
  parameter int WORD_W = 16,
  parameter int OCT_W  = 8,
  parameter int CFG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [1:0]        ctrl_i,
  input  logic [1:0]        mode_i,
  input  logic [CFG_W-1:0]  tail_cfg_i,
  output logic              oct_valid_o,
  input  logic              oct_ready_i,
  output logic [OCT_W-1:0]  oct_o,
  output logic              oct_first_o
);
  spare_mode_e       mode;
  logic [CFG_W-1:0]  prn;
  logic [WORD_W-1:0] word;
  logic              in_fire;

  assign mode    = spare_mode_e'(mode_i);
  assign in_fire = in_valid_i && in_ready_o;

  smp_tail_lfsr #(.LW(CFG_W), .TAPS(CFG_W'(3'b110))) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (mode != SPARE_PRN),
    .seed_i  (tail_cfg_i),
    .adv_i   (in_fire),
    .state_o (prn)
  );

  smp_word_former #(.SMP_W(SMP_W), .WORD_W(WORD_W), .CFG_W(CFG_W)) u_form (
    .sample_i   (sample_i),
    .ctrl_i     (ctrl_i),
    .mode_i     (mode),
    .tail_cfg_i (tail_cfg_i),
    .prn_i      (prn),
    .word_o     (word)
  );

  smp_oct_serializer #(.WORD_W(WORD_W), .OCT_W(OCT_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .word_i      (word),
    .oct_valid_o (oct_valid_o),
    .oct_ready_i (oct_ready_i),
    .oct_o       (oct_o),
    .oct_first_o (oct_first_o)
  );
endmodule

// File: rtl/smp_pack_chk.sv
module smp_pack_chk #(
  parameter int OCT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             oct_valid_o,
  input logic             oct_ready_i,
  input logic [OCT_W-1:0] oct_o,
  input logic             oct_first_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_idle_in_reset_r1: assert (!oct_valid_o && in_ready_o);
    end
  end

  p_hold_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_valid_o && !oct_ready_i |=> oct_valid_o && $stable(oct_o) && $stable(oct_first_o));

  p_load_starts_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> oct_valid_o && oct_first_o);

  p_high_then_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_valid_o && oct_ready_i && oct_first_o |=> oct_valid_o && !oct_first_o);

  p_no_accept_mid_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_valid_o && (oct_first_o || !oct_ready_i) |-> !in_ready_o);

  p_accept_when_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oct_valid_o |-> in_ready_o);
endmodule

bind smp_pack_top smp_pack_chk #(.OCT_W(OCT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .oct_valid_o (oct_valid_o),
  .oct_ready_i (oct_ready_i),
  .oct_o       (oct_o),
  .oct_first_o (oct_first_o)
);

// File: tb/smp_pack_top_tb_top.sv
`timescale 1ns/1ps
module smp_pack_top_tb_top;
  localparam real HALF = 2.5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [13:0] sample_i = '0;
  logic [1:0]  ctrl_i = '0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  tail_cfg_i = '0;
  logic        oct_valid_o;
  logic        oct_ready_i = 1'b0;
  logic [7:0]  oct_o;
  logic        oct_first_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [10:0] expq[$];   // {mode, first, octet}
  logic [2:0]  m_lfsr = 3'b001;
  bit          hold_prev = 0;
  logic [7:0]  prev_oct;
  logic        prev_first;
  int          fires;

  always #(HALF) clk_i = ~clk_i;

  smp_pack_top dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_word(input logic [13:0] s, input logic [1:0] c,
                                           input logic [1:0] m, input logic [2:0] cfg,
                                           input logic [2:0] lf);
    logic [1:0] sp;
    case (m)
      2'd0: sp = cfg[1:0];
      2'd1: sp = lf[1:0];
      2'd2: sp = {c[0], cfg[0]};
      default: sp = c;
    endcase
    return {s, sp};
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2 R4";
      2'd1: return "R2 R5";
      2'd2: return "R2 R6";
      default: return "R2 R7";
    endcase
  endfunction

  // inputs were driven at the last negedge; evaluate what the next posedge does
  task automatic eval();
    logic [10:0] e;
    logic [15:0] w;
    bit          in_fire;
    bit          exp_rdy;
    exp_rdy = !oct_valid_o || (!oct_first_o && oct_ready_i);
    chk(in_ready_o == exp_rdy, "R9 in_ready", in_ready_o, exp_rdy);
    if (hold_prev)
      chk(oct_valid_o && oct_o == prev_oct && oct_first_o == prev_first,
          "R8 hold", {oct_valid_o, oct_o}, {1'b1, prev_oct});
    if (oct_valid_o && oct_ready_i) begin
      fires++;
      if (expq.size() == 0) chk(0, "R3 unexpected octet", oct_o, 0);
      else begin
        e = expq.pop_front();
        chk(oct_first_o == e[8], "R3 order", oct_first_o, e[8]);
        chk(oct_o == e[7:0], mode_tag(e[10:9]), oct_o, e[7:0]);
      end
    end
    in_fire = in_valid_i && in_ready_o;
    if (in_fire) begin
      w = ref_word(sample_i, ctrl_i, mode_i, tail_cfg_i, m_lfsr);
      expq.push_back({mode_i, 1'b1, w[15:8]});
      expq.push_back({mode_i, 1'b0, w[7:0]});
    end
    if (mode_i != 2'd1) m_lfsr = (tail_cfg_i == 3'd0) ? 3'b001 : tail_cfg_i;
    else if (in_fire)   m_lfsr = {m_lfsr[1:0], m_lfsr[2] ^ m_lfsr[1]};
    hold_prev  = oct_valid_o && !oct_ready_i;
    prev_oct   = oct_o;
    prev_first = oct_first_o;
  endtask

  task automatic step(input bit v, input logic [13:0] s, input logic [1:0] c,
                      input logic [1:0] m, input logic [2:0] cfg, input bit r);
    @(negedge clk_i);
    in_valid_i = v; sample_i = s; ctrl_i = c; mode_i = m; tail_cfg_i = cfg; oct_ready_i = r;
    #1;
    eval();
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) step(0, 14'd0, 2'd0, mode_i, tail_cfg_i, 1);
    chk(expq.size() == 0 && !oct_valid_o, "R3 drained", expq.size(), 0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!oct_valid_o && in_ready_o, "R1 in reset", {oct_valid_o, in_ready_o}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!oct_valid_o && in_ready_o, "R1 after reset", {oct_valid_o, in_ready_o}, 2'b01);

    // R4 default zero tail, full rate
    for (int k = 0; k < 8; k++) step(1, 14'(k * 1111 + 5), 2'b11, 2'd0, 3'd0, 1);
    drain();
    // R5 seeded sequence, seed 5, then zero seed
    step(0, 0, 0, 2'd0, 3'd5, 1);
    for (int k = 0; k < 9; k++) step(1, 14'h3fff, 2'b00, 2'd1, 3'd5, 1);
    drain();
    step(0, 0, 0, 2'd0, 3'd0, 1);
    for (int k = 0; k < 9; k++) step(1, 14'h0, 2'b00, 2'd1, 3'd0, 1);
    drain();
    // R6 R7 corner patterns
    step(1, 14'h2aaa, 2'b01, 2'd2, 3'd0, 1);
    step(1, 14'h1555, 2'b10, 2'd2, 3'd1, 1);
    step(1, 14'h0000, 2'b10, 2'd3, 3'd7, 1);
    step(1, 14'h3fff, 2'b01, 2'd3, 3'd0, 1);
    drain();
    // R8 long stall
    step(1, 14'h1234, 2'b00, 2'd0, 3'd2, 0);
    for (int k = 0; k < 5; k++) step(1, 14'h0abc, 2'b00, 2'd0, 3'd2, 0);
    drain();
    // R10 streaming throughput
    step(1, 14'h0101, 2'b11, 2'd1, 3'd3, 1);
    fires = 0;
    for (int k = 0; k < 40; k++) step(1, 14'(k * 77), 2'b11, 2'd1, 3'd3, 1);
    chk(fires == 40, "R10 one octet per cycle", fires, 40);
    drain();
    // constrained random mix
    for (int k = 0; k < 4000; k++)
      step(($urandom % 4) != 0, 14'($urandom), 2'($urandom), 2'($urandom % 4),
           3'($urandom), ($urandom % 3) != 0);
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule